// File: doc/BRIEF.md
# Line Code Violation Detector

This block watches a dual-rail receive stream, one symbol per bit strobe, and raises a violation flag for each offending bit time. A positive mark arrives as `rail_p` high with `rail_n` low. A negative mark arrives as `rail_n` high with `rail_p` low. A space has both rails low. The flag is meant to drive the pin that carries negative data in dual-rail operation. It is reported only while the system runs in single-rail mode.

The `hdb3_mode` input picks the checking rule. In plain alternate-mark-inversion checking, any mark that repeats the polarity of the previous mark is an error. In HDB3 checking, the deliberate same-polarity marks inserted by zero substitution are accepted: both the `000V` and the `B00V` forms. What remains flagged is a genuine code error: a repeated polarity in the wrong place, a substitution mark with the wrong polarity, or a run of four or more spaces. Decoding to NRZ data and pin multiplexing are handled elsewhere.

Top module: `line_code_viol_det`

## Requirements
- R1: After reset the flag is 0, the zero run is 0, and both the last-mark polarity and the last-accepted-substitution polarity count as negative. The first negative mark after reset is therefore a repeat.
- R2: Rails are evaluated only in a clock cycle with `bit_en` high. The flag register takes the result at that edge and holds it until the next strobe. Rail activity without a strobe has no effect.
- R3: A symbol with both rails high is flagged in either mode.
- R4: With `hdb3_mode` = 0, a mark with the same polarity as the previous mark is flagged. Spaces, and marks that alternate polarity, are never flagged, however long the space run.
- R5: With `hdb3_mode` = 1, a same-polarity mark is accepted without a flag when at least two spaces precede it and its polarity is opposite to the last accepted substitution mark. It then becomes the new last-accepted-substitution polarity.
- R6: With `hdb3_mode` = 1, a same-polarity mark preceded by fewer than two spaces is flagged.
- R7: With `hdb3_mode` = 1, a same-polarity mark whose polarity equals the last accepted substitution mark is flagged, and the last-accepted-substitution polarity does not change.
- R8: With `hdb3_mode` = 1, a space that follows three or more consecutive spaces is flagged. This covers the fourth space of a run and every later one.
- R9: While `single_rail` is 0 the `viol` output is 0 in the same cycle, but symbol tracking continues. When `single_rail` returns to 1, the stored flag reappears at once.
- R10: Every lone-rail mark updates the last-mark polarity, whether or not it is flagged. A both-rails symbol leaves both polarities unchanged and clears the zero run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle strobe marking a valid symbol |
| rail_p | input | 1 | Positive rail mark |
| rail_n | input | 1 | Negative rail mark |
| hdb3_mode | input | 1 | 1 selects HDB3 checking, 0 plain bipolar checking |
| single_rail | input | 1 | 1 enables violation reporting |
| viol | output | 1 | Violation flag, one bit period per offending symbol |

## Verification
The bound checker watches, on every cycle, four properties that need no knowledge of stream history:
- the output is silent outside single-rail mode;
- the flag holds between strobes;
- a both-rails symbol always raises the flag;
- a space in plain bipolar mode never raises it.

The polarity-dependent rules depend on the last mark and the last accepted substitution. These are the repeated-mark error, the acceptance of `000V` and `B00V`, the wrong-polarity substitution, the excess zero run, and tracking continuing while reporting is off. Only the bench's directed symbol sequences, with expected flags worked out by hand, can show them.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
    typedef enum logic {
        POL_POS = 1'b0,
        POL_NEG = 1'b1
    } pol_e;

    typedef struct packed {
        logic mark;   // exactly one rail high
        logic both;   // both rails high
        pol_e pol;    // polarity when mark is set
    } sym_t;

    typedef struct packed {
        pol_e last_mark;
        pol_e last_sub;
        logic flag;
    } trk_t;
endpackage

// File: rtl/lcv_classify.sv
module lcv_classify
    import lcv_pkg::*;
(
    input  logic rail_p,
    input  logic rail_n,
    output sym_t sym
);
    always_comb begin
        sym.mark = rail_p ^ rail_n;
        sym.both = rail_p & rail_n;
        sym.pol  = rail_n ? POL_NEG : POL_POS;
    end
endmodule

// File: rtl/lcv_zero_run.sv
module lcv_zero_run #(
    parameter int MAX_ZEROS = 3,
    localparam int CW = $clog2(MAX_ZEROS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_en,
    input  logic          pulse_seen,
    output logic [CW-1:0] run
);
    localparam logic [CW-1:0] RUN_TOP = CW'(MAX_ZEROS);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } zr_t;

    zr_t zr_d, zr_q;

    always_comb begin
        zr_d = zr_q;
        if (bit_en) begin
            if (pulse_seen) begin
                zr_d.cnt = '0;
            end else if (zr_q.cnt != RUN_TOP) begin
                zr_d.cnt = zr_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zr_q <= '0;
        end else begin
            zr_q <= zr_d;
        end
    end

    assign run = zr_q.cnt;
endmodule

// File: rtl/lcv_rule_eval.sv
module lcv_rule_eval
    import lcv_pkg::*;
#(
    parameter int MAX_ZEROS     = 3,
    parameter int SUB_MIN_ZEROS = 2,
    localparam int CW = $clog2(MAX_ZEROS + 1)
) (
    input  sym_t          sym,
    input  logic          hdb3_mode,
    input  logic [CW-1:0] run,
    input  pol_e          last_mark,
    input  pol_e          last_sub,
    output logic          flag,
    output logic          accept_sub
);
    localparam logic [CW-1:0] RUN_TOP = CW'(MAX_ZEROS);
    localparam logic [CW-1:0] SUB_MIN = CW'(SUB_MIN_ZEROS);

    logic repeat_pol;
    logic excess_zero;

    always_comb begin
        repeat_pol  = sym.mark && (sym.pol == last_mark);
        accept_sub  = hdb3_mode && repeat_pol && (run >= SUB_MIN)
                      && (sym.pol != last_sub);
        excess_zero = hdb3_mode && !sym.mark && !sym.both && (run == RUN_TOP);
        flag        = sym.both || (repeat_pol && !accept_sub) || excess_zero;
    end
endmodule

// File: rtl/line_code_viol_det.sv
module line_code_viol_det
    import lcv_pkg::*;
#(
    parameter int MAX_ZEROS     = 3,
    parameter int SUB_MIN_ZEROS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic rail_p,
    input  logic rail_n,
    input  logic hdb3_mode,
    input  logic single_rail,
    output logic viol
);
    localparam int CW = $clog2(MAX_ZEROS + 1);

    sym_t          sym;
    logic [CW-1:0] run;
    logic          flag;
    logic          accept_sub;
    trk_t          trk_d, trk_q;

    lcv_classify u_classify (
        .rail_p (rail_p),
        .rail_n (rail_n),
        .sym    (sym)
    );

    lcv_zero_run #(
        .MAX_ZEROS (MAX_ZEROS)
    ) u_zero_run (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .pulse_seen (sym.mark | sym.both),
        .run        (run)
    );

    lcv_rule_eval #(
        .MAX_ZEROS     (MAX_ZEROS),
        .SUB_MIN_ZEROS (SUB_MIN_ZEROS)
    ) u_rule_eval (
        .sym        (sym),
        .hdb3_mode  (hdb3_mode),
        .run        (run),
        .last_mark  (trk_q.last_mark),
        .last_sub   (trk_q.last_sub),
        .flag       (flag),
        .accept_sub (accept_sub)
    );

    always_comb begin
        trk_d = trk_q;
        if (bit_en) begin
            trk_d.flag = flag;
            if (sym.mark) begin
                trk_d.last_mark = sym.pol;
            end
            if (accept_sub) begin
                trk_d.last_sub = sym.pol;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q.last_mark <= POL_NEG;
            trk_q.last_sub  <= POL_NEG;
            trk_q.flag      <= 1'b0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign viol = trk_q.flag & single_rail;
endmodule

// File: rtl/lcv_checker.sv
module lcv_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic rail_p,
    input logic rail_n,
    input logic hdb3_mode,
    input logic single_rail,
    input logic viol
);
    p_quiet_dual_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !single_rail |-> !viol);

    p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && single_rail) |=> (!single_rail || viol == $past(viol)));

    p_both_rails_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && rail_p && rail_n) |=> (viol || !single_rail));

    p_ami_space_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !hdb3_mode && !rail_p && !rail_n) |=> !viol);
endmodule

bind line_code_viol_det lcv_checker u_chk (.*);

// File: tb/tb_line_code_viol_det.sv
`timescale 1ns/1ps
module tb_line_code_viol_det;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic rail_p = 1'b0;
    logic rail_n = 1'b0;
    logic hdb3_mode = 1'b0;
    logic single_rail = 1'b1;
    logic viol;
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    line_code_viol_det dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_en      (bit_en),
        .rail_p      (rail_p),
        .rail_n      (rail_n),
        .hdb3_mode   (hdb3_mode),
        .single_rail (single_rail),
        .viol        (viol)
    );

    task automatic chk(input logic exp, input string req);
        n_cmp++;
        if (viol !== exp) begin
            n_bad++;
            $display("FAIL %s: viol=%b expected %b", req, viol, exp);
        end
    endtask

    task automatic do_reset(input logic hdb3, input logic srail);
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
        hdb3_mode = hdb3; single_rail = srail;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // drive one strobed symbol, check flag one edge later
    task automatic sym(input logic p, input logic n, input logic exp, input string req);
        @(negedge clk);
        bit_en = 1'b1; rail_p = p; rail_n = n;
        @(negedge clk);
        bit_en = 1'b0; rail_p = 1'b0; rail_n = 1'b0;
        chk(exp, req);
    endtask

    task automatic t_reset;
        do_reset(1'b0, 1'b1);
        chk(1'b0, "R1 reset flag");
        sym(1'b0, 1'b1, 1'b1, "R1 first negative mark repeats reset polarity");
        do_reset(1'b0, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R1 first positive mark clean");
    endtask

    task automatic t_ami;
        do_reset(1'b0, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R4 P");
        sym(1'b0, 1'b1, 1'b0, "R4 N alternates");
        for (int i = 0; i < 5; i++) sym(1'b0, 1'b0, 1'b0, "R4 long space run");
        sym(1'b1, 1'b0, 1'b0, "R4 P after spaces");
        sym(1'b1, 1'b0, 1'b1, "R4 repeated P");
        sym(1'b0, 1'b1, 1'b0, "R10 N after flagged P");
        sym(1'b0, 1'b1, 1'b1, "R4 repeated N");
        sym(1'b0, 1'b0, 1'b0, "R4 space clears flag");
    endtask

    task automatic t_strobe;
        do_reset(1'b0, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R2 P");
        @(negedge clk);
        rail_n = 1'b1;
        @(negedge clk);
        rail_p = 1'b1;
        @(negedge clk);
        rail_p = 1'b0; rail_n = 1'b0;
        chk(1'b0, "R2 unstrobed rails ignored");
        sym(1'b0, 1'b1, 1'b0, "R2 N still alternates");
        sym(1'b0, 1'b1, 1'b1, "R2 repeat N");
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(1'b1, "R2 flag held between strobes");
        end
    endtask

    task automatic t_both;
        do_reset(1'b0, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R3 P");
        sym(1'b1, 1'b1, 1'b1, "R3 both rails bipolar mode");
        sym(1'b0, 1'b1, 1'b0, "R10 both rails left polarity");
        do_reset(1'b1, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R3 P hdb3");
        sym(1'b0, 1'b0, 1'b0, "R3 space");
        sym(1'b0, 1'b0, 1'b0, "R3 space");
        sym(1'b1, 1'b1, 1'b1, "R3 both rails hdb3 mode");
        sym(1'b0, 1'b0, 1'b0, "R10 space after both");
        sym(1'b0, 1'b0, 1'b0, "R10 space after both");
        sym(1'b0, 1'b0, 1'b0, "R10 third space, run was cleared");
    endtask

    task automatic t_sub_ok;
        do_reset(1'b1, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R5 P");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R5 space");
        sym(1'b1, 1'b0, 1'b0, "R5 000V positive accepted");
        sym(1'b0, 1'b1, 1'b0, "R5 B negative");
        for (int i = 0; i < 2; i++) sym(1'b0, 1'b0, 1'b0, "R5 space");
        sym(1'b0, 1'b1, 1'b0, "R5 B00V negative accepted");
        sym(1'b1, 1'b0, 1'b0, "R5 P");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R5 space");
        sym(1'b1, 1'b0, 1'b0, "R5 000V positive after negative V");
    endtask

    task automatic t_sub_bad;
        do_reset(1'b1, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R6 P");
        sym(1'b0, 1'b0, 1'b0, "R6 space");
        sym(1'b1, 1'b0, 1'b1, "R6 repeat after one space");
        sym(1'b1, 1'b0, 1'b1, "R6 repeat after no space");
        do_reset(1'b1, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R7 P");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R7 space");
        sym(1'b1, 1'b0, 1'b0, "R7 V positive accepted");
        sym(1'b0, 1'b1, 1'b0, "R7 N");
        sym(1'b1, 1'b0, 1'b0, "R7 P");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R7 space");
        sym(1'b1, 1'b0, 1'b1, "R7 V same polarity as last V");
        sym(1'b0, 1'b1, 1'b0, "R7 N");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R7 space");
        sym(1'b0, 1'b1, 0, "R7 rejected V not recorded");
    endtask

    task automatic t_zeros;
        do_reset(1'b1, 1'b1);
        sym(1'b1, 1'b0, 1'b0, "R8 P");
        for (int i = 0; i < 3; i++) sym(1'b0, 1'b0, 1'b0, "R8 up to three spaces");
        sym(1'b0, 1'b0, 1'b1, "R8 fourth space");
        sym(1'b0, 1'b0, 1'b1, "R8 fifth space");
        sym(1'b0, 1'b1, 1'b0, "R8 N ends run");
    endtask

    task automatic t_gate;
        do_reset(1'b0, 1'b0);
        sym(1'b1, 1'b0, 1'b0, "R9 P gated");
        sym(1'b1, 1'b0, 1'b0, "R9 repeat P gated");
        @(negedge clk);
        single_rail = 1'b1;
        #1;
        chk(1'b1, "R9 stored flag shows on enable");
        sym(1'b0, 1'b1, 1'b0, "R9 tracking continued");
        sym(1'b0, 1'b1, 1'b1, "R9 repeat N reported");
        @(negedge clk);
        single_rail = 1'b0;
        #1;
        chk(1'b0, "R9 immediate quiet");
        single_rail = 1'b1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset;
        t_ami;
        t_strobe;
        t_both;
        t_sub_ok;
        t_sub_bad;
        t_zeros;
        t_gate;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule